// File: doc/BRIEF.md
# E1 Signaling-Slot Spare Bit Link

This block carries three slow spare-bit data channels inside the multiframe alignment byte of the E1 signaling time slot. That slot is time slot 16 of frame 0 of each 16-frame channel-associated-signaling multiframe. Each spare bit forms an independent 0.5 kbit/s channel to and from the far end.

On the transmit side, the block takes the outgoing signaling-slot byte stream from the framer. In the frame 0 slot it replaces that byte with the alignment pattern, the three host-programmed spare bits and a separately supplied Y bit. Every other byte passes through unchanged. The host's spare-bit setting is sampled once, at the start of each multiframe, so that no multiframe mixes old and new values.

On the receive side, the block picks the three spare bits out of the frame 0 signaling-slot byte. It holds them in a status field that updates once per multiframe. While the framer reports loss of signaling-slot multiframe alignment, the field reads all ones. The framer supplies the frame and time-slot position with a byte strobe, so alignment search stays outside the block.

Top module: `e1_xlink`

## Requirements
- R1: After reset, `rx_x_status` reads 3'b111, `tx_byte_vld` is 0, and the transmit spare bits in use are 3'b111 until the first multiframe start.
- R2: A strobed byte with `frm_num`=0 and `ts_num`=16 (the X slot) appears on `tx_byte_out` one clock after its strobe, with `tx_byte_vld` high. Bits 7..4 are 0, bit 3 is spare bit 0, bit 1 is spare bit 1, and bit 0 is spare bit 2.
- R3: Every other strobed byte appears unchanged on `tx_byte_out` one clock after its strobe, with `tx_byte_vld` high. Exactly one output byte is produced for each strobe.
- R4: `tx_x_cfg` is sampled only on the strobe with `frm_num`=0 and `ts_num`=0 (multiframe start). A change made after that strobe reaches the line at the next multiframe.
- R5: Bit 2 of the X-slot output byte equals `tx_y_in` as sampled with the X-slot strobe.
- R6: While alignment is held, the X-slot strobe loads `rx_x_status`. It takes {bit 0, bit 1, bit 3} of `rx_byte_in` (status bit 2 from byte bit 0, status bit 1 from byte bit 1, status bit 0 from byte bit 3), visible one clock later.
- R7: Receive bytes in any other slot or frame do not change `rx_x_status`.
- R8: While `rx_mfa_lost` is high, `rx_x_status` reads 3'b111 from the next clock on. An X-slot byte received during loss is ignored. The status stays all ones until the next X slot captured with alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_stb | input | 1 | One-cycle strobe per time-slot byte |
| frm_num | input | FRM_W | Frame index within the signaling multiframe |
| ts_num | input | TS_W | Time-slot index within the frame |
| tx_x_cfg | input | 3 | Host spare-bit values for transmit |
| tx_y_in | input | 1 | Y bit to place in the X-slot byte |
| tx_byte_in | input | 8 | Outgoing signaling-slot byte from the framer |
| tx_byte_out | output | 8 | Outgoing byte with spare bits inserted |
| tx_byte_vld | output | 1 | `tx_byte_out` carries a new byte |
| rx_byte_in | input | 8 | Incoming signaling-slot byte |
| rx_mfa_lost | input | 1 | Signaling-slot multiframe alignment lost |
| rx_x_status | output | 3 | Received spare bits |

## Verification
The bench builds the block with its defaults: a 4-bit frame index, a 5-bit slot index and the X slot at time slot 16. This gives full 16-frame by 32-slot multiframes. It allows X-slot look-alike bytes in other frames and slots, configuration changes before and after the multiframe-start strobe, and alignment loss both across the X slot and after a capture. A first X-slot byte is sent before any multiframe start, so the reset spare-bit value reaches the line.

// File: rtl/e1_xlink_pkg.sv
package e1_xlink_pkg;

  localparam int unsigned NX     = 3;
  localparam int unsigned BYTE_W = 8;

  // bit positions inside the X-slot byte (bit 7 is sent first)
  localparam int unsigned XB0 = 3;
  localparam int unsigned YB  = 2;
  localparam int unsigned XB1 = 1;
  localparam int unsigned XB2 = 0;

  localparam logic [3:0] MAS_PAT = 4'b0000;
  localparam logic [NX-1:0] X_IDLE = '1;

  function automatic logic [BYTE_W-1:0] build_x_byte(input logic [NX-1:0] xv,
                                                       input logic        y);
    logic [BYTE_W-1:0] b;
    b          = '0;
    b[7:4]     = MAS_PAT;
    b[XB0]     = xv[0];
    b[YB]      = y;
    b[XB1]     = xv[1];
    b[XB2]     = xv[2];
    return b;
  endfunction

  function automatic logic [NX-1:0] pull_x(input logic [BYTE_W-1:0] b);
    logic [NX-1:0] xv;
    xv[0] = b[XB0];
    xv[1] = b[XB1];
    xv[2] = b[XB2];
    return xv;
  endfunction

endpackage

// File: rtl/e1_xlink_pos.sv
module e1_xlink_pos #(
  parameter int unsigned FRM_W  = 4,
  parameter int unsigned TS_W   = 5,
  parameter int unsigned SIG_TS = 16
) (
  input  logic             byte_stb,
  input  logic [FRM_W-1:0] frm_num,
  input  logic [TS_W-1:0]  ts_num,
  output logic             mf_start_evt,
  output logic             x_slot_evt
);

  localparam logic [TS_W-1:0] SIG_SLOT = TS_W'(SIG_TS);

  logic frame0;

  always_comb begin
    frame0       = (frm_num == '0);
    mf_start_evt = byte_stb && frame0 && (ts_num == '0);
    x_slot_evt   = byte_stb && frame0 && (ts_num == SIG_SLOT);
  end

endmodule

// File: rtl/e1_xlink_tx.sv
module e1_xlink_tx
  import e1_xlink_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_stb,
  input  logic              mf_start_evt,
  input  logic              x_slot_evt,
  input  logic [NX-1:0]     tx_x_cfg,
  input  logic              tx_y_in,
  input  logic [BYTE_W-1:0] tx_byte_in,
  output logic [NX-1:0]     tx_x_active,
  output logic [BYTE_W-1:0] tx_byte_out,
  output logic              tx_byte_vld
);

  logic [NX-1:0]     act_q;
  logic [BYTE_W-1:0] out_q;
  logic              vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= X_IDLE;
    end else if (mf_start_evt) begin
      act_q <= tx_x_cfg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= byte_stb;
      if (x_slot_evt) begin
        out_q <= build_x_byte(act_q, tx_y_in);
      end else if (byte_stb) begin
        out_q <= tx_byte_in;
      end
    end
  end

  assign tx_x_active = act_q;
  assign tx_byte_out = out_q;
  assign tx_byte_vld = vld_q;

endmodule

// File: rtl/e1_xlink_rx.sv
module e1_xlink_rx
  import e1_xlink_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              x_slot_evt,
  input  logic              rx_mfa_lost,
  input  logic [BYTE_W-1:0] rx_byte_in,
  output logic              rx_cap_evt,
  output logic [NX-1:0]     rx_x_status
);

  logic [NX-1:0] stat_q;

  assign rx_cap_evt = x_slot_evt && !rx_mfa_lost;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= X_IDLE;
    end else if (rx_mfa_lost) begin
      stat_q <= X_IDLE;
    end else if (rx_cap_evt) begin
      stat_q <= pull_x(rx_byte_in);
    end
  end

  assign rx_x_status = stat_q;

endmodule

// File: rtl/e1_xlink.sv
module e1_xlink
  import e1_xlink_pkg::*;
#(
  parameter int unsigned FRM_W  = 4,
  parameter int unsigned TS_W   = 5,
  parameter int unsigned SIG_TS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_stb,
  input  logic [FRM_W-1:0] frm_num,
  input  logic [TS_W-1:0]  ts_num,
  input  logic [2:0]       tx_x_cfg,
  input  logic             tx_y_in,
  input  logic [7:0]       tx_byte_in,
  output logic [7:0]       tx_byte_out,
  output logic             tx_byte_vld,
  input  logic [7:0]       rx_byte_in,
  input  logic             rx_mfa_lost,
  output logic [2:0]       rx_x_status
);

  logic          mf_start_evt;
  logic          x_slot_evt;
  logic          rx_cap_evt;
  logic [NX-1:0] tx_x_active;

  e1_xlink_pos #(.FRM_W(FRM_W), .TS_W(TS_W), .SIG_TS(SIG_TS)) u_pos (
    .byte_stb     (byte_stb),
    .frm_num      (frm_num),
    .ts_num       (ts_num),
    .mf_start_evt (mf_start_evt),
    .x_slot_evt   (x_slot_evt)
  );

  e1_xlink_tx u_tx (
    .clk          (clk),
    .rst_n        (rst_n),
    .byte_stb     (byte_stb),
    .mf_start_evt (mf_start_evt),
    .x_slot_evt   (x_slot_evt),
    .tx_x_cfg     (tx_x_cfg),
    .tx_y_in      (tx_y_in),
    .tx_byte_in   (tx_byte_in),
    .tx_x_active  (tx_x_active),
    .tx_byte_out  (tx_byte_out),
    .tx_byte_vld  (tx_byte_vld)
  );

  e1_xlink_rx u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .x_slot_evt   (x_slot_evt),
    .rx_mfa_lost  (rx_mfa_lost),
    .rx_byte_in   (rx_byte_in),
    .rx_cap_evt   (rx_cap_evt),
    .rx_x_status  (rx_x_status)
  );

endmodule

// File: rtl/e1_xlink_chk.sv
module e1_xlink_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       byte_stb,
  input logic       mf_start_evt,
  input logic       x_slot_evt,
  input logic [2:0] tx_x_active,
  input logic       tx_y_in,
  input logic [7:0] tx_byte_in,
  input logic [7:0] tx_byte_out,
  input logic       tx_byte_vld,
  input logic [7:0] rx_byte_in,
  input logic       rx_mfa_lost,
  input logic [2:0] rx_x_status
);

  AST_TX_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |=> tx_byte_vld); // R3
  AST_TX_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_stb |=> !tx_byte_vld); // R3
  AST_TX_MAS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    x_slot_evt |=> (tx_byte_out[7:4] == 4'b0000)); // R2
  AST_TX_X_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    x_slot_evt |=> ({tx_byte_out[0], tx_byte_out[1], tx_byte_out[3]} == $past(tx_x_active))); // R2
  AST_TX_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && !x_slot_evt) |=> (tx_byte_out == $past(tx_byte_in))); // R3
  AST_TX_Y_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    x_slot_evt |=> (tx_byte_out[2] == $past(tx_y_in))); // R5
  AST_TX_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mf_start_evt |=> $stable(tx_x_active)); // R4
  AST_RX_FORCE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    rx_mfa_lost |=> (rx_x_status == 3'b111)); // R8
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_mfa_lost && !x_slot_evt) |=> $stable(rx_x_status)); // R7
  AST_RX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (x_slot_evt && !rx_mfa_lost) |=>
      (rx_x_status == {$past(rx_byte_in[0]), $past(rx_byte_in[1]), $past(rx_byte_in[3])})); // R6

endmodule

bind e1_xlink e1_xlink_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .byte_stb     (byte_stb),
  .mf_start_evt (mf_start_evt),
  .x_slot_evt   (x_slot_evt),
  .tx_x_active  (tx_x_active),
  .tx_y_in      (tx_y_in),
  .tx_byte_in   (tx_byte_in),
  .tx_byte_out  (tx_byte_out),
  .tx_byte_vld  (tx_byte_vld),
  .rx_byte_in   (rx_byte_in),
  .rx_mfa_lost  (rx_mfa_lost),
  .rx_x_status  (rx_x_status)
);

// File: tb/sim_e1_xlink.sv
module sim_e1_xlink;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       byte_stb;
  logic [3:0] frm_num;
  logic [4:0] ts_num;
  logic [2:0] tx_x_cfg;
  logic       tx_y_in;
  logic [7:0] tx_byte_in;
  logic [7:0] tx_byte_out;
  logic       tx_byte_vld;
  logic [7:0] rx_byte_in;
  logic       rx_mfa_lost;
  logic [2:0] rx_x_status;

  always #5 clk = ~clk;

  e1_xlink u0 (
    .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .frm_num(frm_num),
    .ts_num(ts_num), .tx_x_cfg(tx_x_cfg), .tx_y_in(tx_y_in),
    .tx_byte_in(tx_byte_in), .tx_byte_out(tx_byte_out), .tx_byte_vld(tx_byte_vld),
    .rx_byte_in(rx_byte_in), .rx_mfa_lost(rx_mfa_lost), .rx_x_status(rx_x_status)
  );

  int         n_cmp = 0;
  int         n_bad = 0;
  bit         finished = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [2:0] act_m = 3'b111;
  logic [2:0] exp_rx = 3'b111;

  task automatic check(string tag, logic [7:0] got, logic [7:0] want);
    n_cmp++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, want, $time);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // monitor: pop one expected transmit byte for each valid output
  always @(negedge clk) begin
    if (rst_n === 1'b1 && tx_byte_vld === 1'b1) begin
      if (exp_q.size() == 0) begin
        check("R3 unexpected output byte", 8'h01, 8'h00);
      end else begin
        check(tag_q.pop_front(), tx_byte_out, exp_q.pop_front());
      end
    end
  end

  // driver: present one strobed byte and record expectations
  task automatic put_byte(int frm, int ts, logic [7:0] txb, logic [7:0] rxb);
    logic [7:0] want;
    frm_num    = 4'(frm);
    ts_num     = 5'(ts);
    tx_byte_in = txb;
    rx_byte_in = rxb;
    byte_stb   = 1'b1;
    if (frm == 0 && ts == 0) act_m = tx_x_cfg;
    if (frm == 0 && ts == 16) begin
      want = {4'h0, act_m[0], tx_y_in, act_m[1], act_m[2]};
      exp_q.push_back(want);
      tag_q.push_back("R2/R4/R5 X-slot transmit byte");
    end else begin
      exp_q.push_back(txb);
      tag_q.push_back("R3 pass-through byte");
    end
    if (rx_mfa_lost) exp_rx = 3'b111;
    else if (frm == 0 && ts == 16) exp_rx = {rxb[0], rxb[1], rxb[3]};
    @(negedge clk);
    if (rx_mfa_lost) check("R8 status forced while lost", {5'd0, rx_x_status}, {5'd0, exp_rx});
    else if (frm == 0 && ts == 16) check("R6 status capture", {5'd0, rx_x_status}, {5'd0, exp_rx});
    else check("R7 status unchanged", {5'd0, rx_x_status}, {5'd0, exp_rx});
  endtask

  task automatic run_mf(logic [2:0] rx_x, logic [2:0] cfg_new, int chg_ts,
                        int lost_lo, int lost_hi, logic y, int seed);
    tx_y_in = y;
    for (int frm = 0; frm < 16; frm++) begin
      for (int ts = 0; ts < 32; ts++) begin
        logic [7:0] rxb;
        if (frm == 0 && ts == chg_ts) tx_x_cfg = cfg_new;
        rx_mfa_lost = (frm >= lost_lo) && (frm < lost_hi);
        if (frm == 0 && ts == 16) rxb = {4'hA, rx_x[0], 1'b0, rx_x[1], rx_x[2]};
        else rxb = 8'(frm * 37 + ts * 11 + seed) ^ 8'h96;
        put_byte(frm, ts, 8'(frm * 29 + ts * 7 + seed), rxb);
      end
    end
    rx_mfa_lost = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    rst_n = 1'b0; byte_stb = 1'b0; frm_num = '0; ts_num = '0;
    tx_x_cfg = 3'b000; tx_y_in = 1'b0; tx_byte_in = '0;
    rx_byte_in = '0; rx_mfa_lost = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset rx status", {5'd0, rx_x_status}, 8'h07);
    check("R1 reset tx valid", {7'd0, tx_byte_vld}, 8'h00);
    // X slot before any multiframe start: reset spare bits 111 on the line (R1)
    tx_y_in = 1'b1;
    put_byte(0, 16, 8'hFF, 8'h0F);
    // R4: new setting applied at the start strobe
    run_mf(3'b101, 3'b010, 0, 99, 99, 1'b1, 3);
    // R4: change after the start strobe is deferred
    run_mf(3'b011, 3'b110, 5, 99, 99, 1'b0, 17);
    run_mf(3'b100, 3'b110, 31, 99, 99, 1'b0, 40);
    // R8: loss across the X slot, then recovery without capture
    run_mf(3'b000, 3'b001, 20, 0, 8, 1'b1, 61);
    run_mf(3'b110, 3'b001, 0, 99, 99, 1'b0, 88);
    // R8: loss after a capture
    run_mf(3'b001, 3'b100, 0, 3, 5, 1'b1, 120);
    run_mf(3'b010, 3'b011, 0, 99, 99, 1'b1, 7);
    byte_stb = 1'b0;
    repeat (3) @(negedge clk);
    check("R3 all bytes produced", 8'(exp_q.size()), 8'h00);
    report();
  end

endmodule